// File: doc/BRIEF.md
# Asynchronous-Framed Serial Transmitter

This block turns 32-bit longwords from a transmit data queue into a stream of framed bytes on a single output line. Each byte goes out as a start bit, eight data bits, a parity bit and one stop period at the marking level. Two independent controls choose which byte lane of the longword is sent first and whether each byte is sent least- or most-significant bit first. Between them they give four serialization orders for a longword. Parity sense, start-bit sense, the clock edge on which the line changes, and whether the block drives the send-timing clock or follows an external one can all be set at run time.

Packets are a whole number of longwords. Their length comes either from a static length input or from a separate queue of length descriptors, with one descriptor taken per packet. If the data queue runs dry in the middle of a packet, the block latches a sticky underflow status, abandons the packet and returns the line to marking. A second condition flags when the data queue level is at or below a programmable threshold. Each condition has its own interrupt enable. The queues, the clock source and the host register file lie outside the block. A half-period tick input stands in for the internal bit clock.

Top module: `serial_frame_tx`

## Requirements
- R1: While no frame is in flight the line holds the marking level, the inverse of the start level. The start bit is 1 when `cfg_start_hi`=1 and 0 when it is 0.
- R2: Each byte is sent as 11 bit periods: start, eight data bits, parity, and exactly one stop period at the marking level. Bytes of one packet follow each other with no extra gap.
- R3: With `cfg_byte_rev`=0 the bytes of a longword go out as bits 7:0, 15:8, 23:16 and then 31:24. With `cfg_byte_rev`=1 the order is 31:24, 23:16, 15:8 and then 7:0.
- R4: With `cfg_bit_rev`=0 each byte is sent bit 0 first. With `cfg_bit_rev`=1 it is sent bit 7 first. Start, parity and stop are never reordered.
- R5: The parity bit makes the count of ones over the eight data bits plus parity even when `cfg_odd_par`=0 and odd when it is 1.
- R6: With `cfg_clk_inv`=0 the line changes only after a rising edge of the bit clock and is stable at the falling edge. With `cfg_clk_inv`=1 the edges swap roles.
- R7: With `cfg_clk_gen`=1 the bit clock is generated internally: it toggles on each `half_ce` tick, `st_clk_out` drives it and `st_clk_oe`=1. With `cfg_clk_gen`=0 the bit clock is the synchronized `ext_sclk`, `st_clk_oe`=0 and `st_clk_out`=0.
- R8: With `cfg_reg_pkt`=1 each packet carries `cfg_pkt_len` longwords, one `fifo_pop` per longword, and the line then returns to marking.
- R9: With `cfg_reg_pkt`=0 a packet starts only when a descriptor is present. One descriptor is popped per packet, and a zero-length descriptor is popped without sending anything. While no descriptor is present, no data is popped and the line stays marking.
- R10: If a further longword is needed mid-packet while `fifo_empty`=1, `uf_sts` is set, the packet is abandoned at marking, and `uf_sts` stays set until a `uf_clr` pulse.
- R11: `uf_sts` contributes to `irq` only when `cfg_uf_ie`=1.
- R12: `ae_sts` is 1 when `fifo_level` <= `cfg_ae_thresh`, and it contributes to `irq` only when `cfg_ae_ie`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_ce | input | 1 | Half-bit-period tick of the internal bit clock |
| ext_sclk | input | 1 | Externally supplied send-timing clock |
| cfg_clk_gen | input | 1 | 1: generate bit clock internally, 0: follow ext_sclk |
| cfg_clk_inv | input | 1 | Selects the bit clock edge on which the line changes |
| cfg_byte_rev | input | 1 | Byte-lane order select |
| cfg_bit_rev | input | 1 | In-byte bit order select |
| cfg_odd_par | input | 1 | 0 even parity, 1 odd parity |
| cfg_start_hi | input | 1 | Start bit active level |
| cfg_reg_pkt | input | 1 | 1: length from cfg_pkt_len, 0: from descriptor queue |
| cfg_pkt_len | input | LEN_W | Static packet length in longwords |
| cfg_ae_thresh | input | LVL_W | Almost-empty threshold |
| cfg_ae_ie | input | 1 | Almost-empty interrupt enable |
| cfg_uf_ie | input | 1 | Underflow interrupt enable |
| uf_clr | input | 1 | Write-one-to-clear pulse for uf_sts |
| fifo_rdata | input | WORD_W | Head longword of the data queue |
| fifo_empty | input | 1 | Data queue empty |
| fifo_level | input | LVL_W | Data queue fill level |
| fifo_pop | output | 1 | Pops the data queue head |
| desc_len | input | LEN_W | Head descriptor length in longwords |
| desc_empty | input | 1 | Descriptor queue empty |
| desc_pop | output | 1 | Pops the descriptor queue head |
| tx_line | output | 1 | Serial output line |
| st_clk_out | output | 1 | Generated send-timing clock |
| st_clk_oe | output | 1 | Drive enable for st_clk_out |
| uf_sts | output | 1 | Sticky underflow status |
| ae_sts | output | 1 | Almost-empty status |
| irq | output | 1 | Combined enabled interrupt |

## Verification
The hardest state to reach is an underflow. It needs a packet whose length exceeds the data on hand, with the queue running dry exactly at a longword boundary after the last stop bit. The bench sets a static length of three longwords but supplies only one. It then checks that exactly four clean frames appear before the line settles at marking, and that the status survives a change of the interrupt enable until the clear pulse. The four serialization orders are swept together with both parity senses, both start senses and both clock edges. Every received bit is captured at the stable edge of the bit clock and compared with frames rebuilt in the bench from the requirements.

// File: rtl/tx_ser_pkg.sv
package tx_ser_pkg;
  // position of the frame currently on the line
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_START = 3'd1,
    S_DATA  = 3'd2,
    S_PAR   = 3'd3,
    S_STOP  = 3'd4
  } txs_t;

  // what the line register shows
  typedef enum logic [1:0] {
    SYM_MARK  = 2'd0,
    SYM_START = 2'd1,
    SYM_BIT   = 2'd2
  } sym_t;
endpackage

// File: rtl/tx_clk_edge.sv
module tx_clk_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic half_ce,
  input  logic ext_sclk,
  input  logic cfg_clk_gen,
  input  logic cfg_clk_inv,
  output logic launch,
  output logic st_clk_out,
  output logic st_clk_oe
);
  logic ph_q, ph_d;
  logic lvl, lvl_prev_q;
  logic ext_s;
  logic [SYNC_STAGES-1:0] sync_q;

  // internal bit clock phase
  always_comb begin
    ph_d = ph_q;
    if (cfg_clk_gen && half_ce) ph_d = ~ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end

  // synchronizer for the external timing clock
  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], ext_sclk};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= ext_sclk;
      end
    end
  endgenerate
  assign ext_s = sync_q[SYNC_STAGES-1];

  assign lvl = cfg_clk_gen ? ph_q : ext_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_prev_q <= 1'b0;
    else        lvl_prev_q <= lvl;
  end

  // launch edge: rising when not inverted, falling when inverted
  assign launch     = (lvl != lvl_prev_q) && (lvl == ~cfg_clk_inv);
  assign st_clk_out = cfg_clk_gen ? ph_q : 1'b0;
  assign st_clk_oe  = cfg_clk_gen;

  // R7: without a tick the generated clock cannot produce a launch next cycle
  p_no_tick_no_launch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_clk_gen && !half_ce) |=> (!cfg_clk_gen || !launch));

  // R7: the output clock is quiet when the external clock is followed
  p_quiet_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_clk_gen |-> (!st_clk_out && !st_clk_oe));
endmodule

// File: rtl/tx_lane_sel.sv
module tx_lane_sel #(
  parameter int WORD_W = 32,
  localparam int NBYTES = WORD_W / 8,
  localparam int BI_W   = $clog2(NBYTES)
) (
  input  logic [WORD_W-1:0] word,
  input  logic [BI_W-1:0]   byte_idx,
  input  logic [2:0]        bit_idx,
  input  logic              byte_rev,
  input  logic              bit_rev,
  input  logic              odd_par,
  output logic              dbit,
  output logic              par
);
  logic [BI_W-1:0] lane;
  logic [7:0]      sel_byte;
  logic [2:0]      pos;

  always_comb begin
    lane     = byte_rev ? (BI_W'(NBYTES - 1) - byte_idx) : byte_idx;
    sel_byte = word[{lane, 3'b000} +: 8];
    pos      = bit_rev ? (3'd7 - bit_idx) : bit_idx;
    dbit     = sel_byte[pos];
    par      = (^sel_byte) ^ odd_par;
  end
endmodule

// File: rtl/tx_frame_fsm.sv
module tx_frame_fsm
  import tx_ser_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 8,
  localparam int NBYTES = WORD_W / 8,
  localparam int BI_W   = $clog2(NBYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              cfg_start_hi,
  input  logic              cfg_reg_pkt,
  input  logic [LEN_W-1:0]  cfg_pkt_len,
  input  logic [WORD_W-1:0] fifo_rdata,
  input  logic              fifo_empty,
  input  logic [LEN_W-1:0]  desc_len,
  input  logic              desc_empty,
  input  logic              lane_bit,
  input  logic              lane_par,
  output logic [WORD_W-1:0] word_q,
  output logic [BI_W-1:0]   byte_q,
  output logic [2:0]        nxt_bit,
  output logic              fifo_pop,
  output logic              desc_pop,
  output logic              uf_evt,
  output logic              tx_line
);
  localparam logic [BI_W-1:0] LAST_BYTE = BI_W'(NBYTES - 1);

  txs_t              st_q, st_d;
  sym_t              sym_q, sym_d;
  logic              dbit_q, dbit_d;
  logic [WORD_W-1:0] word_d;
  logic [BI_W-1:0]   byte_d;
  logic [2:0]        bit_q, bit_d;
  logic [LEN_W-1:0]  wleft_q, wleft_d;
  logic              len_avail;
  logic [LEN_W-1:0]  len_val;

  // index of the data bit to be launched next
  assign nxt_bit = (st_q == S_DATA) ? (bit_q + 3'd1) : 3'd0;

  always_comb begin
    st_d     = st_q;
    sym_d    = sym_q;
    dbit_d   = dbit_q;
    word_d   = word_q;
    byte_d   = byte_q;
    bit_d    = bit_q;
    wleft_d  = wleft_q;
    fifo_pop = 1'b0;
    desc_pop = 1'b0;
    uf_evt   = 1'b0;
    len_avail = cfg_reg_pkt ? 1'b1 : !desc_empty;
    len_val   = cfg_reg_pkt ? cfg_pkt_len : desc_len;
    if (launch) begin
      unique case (st_q)
        S_IDLE: begin
          if (len_avail && (len_val == '0) && !cfg_reg_pkt) begin
            desc_pop = 1'b1;             // empty packet: consume and skip
          end else if (len_avail && (len_val != '0) && !fifo_empty) begin
            fifo_pop = 1'b1;
            desc_pop = !cfg_reg_pkt;
            word_d   = fifo_rdata;
            wleft_d  = len_val - 1'b1;
            byte_d   = '0;
            sym_d    = SYM_START;
            st_d     = S_START;
          end
        end
        S_START: begin
          sym_d  = SYM_BIT;
          dbit_d = lane_bit;
          bit_d  = 3'd0;
          st_d   = S_DATA;
        end
        S_DATA: begin
          if (bit_q == 3'd7) begin
            dbit_d = lane_par;
            st_d   = S_PAR;
          end else begin
            dbit_d = lane_bit;
            bit_d  = bit_q + 3'd1;
          end
        end
        S_PAR: begin
          sym_d = SYM_MARK;
          st_d  = S_STOP;
        end
        S_STOP: begin
          if (byte_q != LAST_BYTE) begin
            byte_d = byte_q + 1'b1;
            sym_d  = SYM_START;
            st_d   = S_START;
          end else if (wleft_q != '0) begin
            if (fifo_empty) begin
              uf_evt = 1'b1;             // abandon packet at marking
              st_d   = S_IDLE;
            end else begin
              fifo_pop = 1'b1;
              word_d   = fifo_rdata;
              wleft_d  = wleft_q - 1'b1;
              byte_d   = '0;
              sym_d    = SYM_START;
              st_d     = S_START;
            end
          end else begin
            st_d = S_IDLE;
          end
        end
        default: begin
          st_d  = S_IDLE;
          sym_d = SYM_MARK;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      sym_q   <= SYM_MARK;
      dbit_q  <= 1'b0;
      word_q  <= '0;
      byte_q  <= '0;
      bit_q   <= 3'd0;
      wleft_q <= '0;
    end else begin
      st_q    <= st_d;
      sym_q   <= sym_d;
      dbit_q  <= dbit_d;
      word_q  <= word_d;
      byte_q  <= byte_d;
      bit_q   <= bit_d;
      wleft_q <= wleft_d;
    end
  end

  always_comb begin
    unique case (sym_q)
      SYM_START: tx_line = cfg_start_hi;
      SYM_BIT:   tx_line = dbit_q;
      default:   tx_line = ~cfg_start_hi;
    endcase
  end

  // R10: data is only taken on a launch and never from an empty queue
  p_pop_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (launch && !fifo_empty));

  // R10: underflow only when the queue is empty and nothing is popped
  p_uf_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt |-> (fifo_empty && !fifo_pop));

  // R9: descriptors are consumed only in descriptor mode, from idle
  p_desc_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    desc_pop |-> (!cfg_reg_pkt && !desc_empty && st_q == S_IDLE));

  // R2: the stop period shows the marking level
  p_stop_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_STOP) |-> (tx_line == ~cfg_start_hi));

  // R6: the line moves only after a launch edge
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> ($stable(tx_line) || !$stable(cfg_start_hi)));
endmodule

// File: rtl/tx_irq_ctl.sv
module tx_irq_ctl #(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uf_evt,
  input  logic             uf_clr,
  input  logic             cfg_uf_ie,
  input  logic             cfg_ae_ie,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [LVL_W-1:0] cfg_ae_thresh,
  output logic             uf_sts,
  output logic             ae_sts,
  output logic             irq
);
  logic uf_d;

  // set wins over a simultaneous clear
  always_comb begin
    uf_d = uf_sts;
    if (uf_clr) uf_d = 1'b0;
    if (uf_evt) uf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uf_sts <= 1'b0;
    else        uf_sts <= uf_d;
  end

  assign ae_sts = (fifo_level <= cfg_ae_thresh);
  assign irq    = (uf_sts & cfg_uf_ie) | (ae_sts & cfg_ae_ie);

  // R10: status holds until cleared
  p_uf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_sts && !uf_clr) |=> uf_sts);

  // R10: an underflow event always leaves the status set
  p_uf_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt |=> uf_sts);

  // R11: R12: masked sources never interrupt
  p_irq_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_uf_ie && !cfg_ae_ie) |-> !irq);
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
  parameter int WORD_W      = 32,
  parameter int LEN_W       = 8,
  parameter int LVL_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_ce,
  input  logic              ext_sclk,
  input  logic              cfg_clk_gen,
  input  logic              cfg_clk_inv,
  input  logic              cfg_byte_rev,
  input  logic              cfg_bit_rev,
  input  logic              cfg_odd_par,
  input  logic              cfg_start_hi,
  input  logic              cfg_reg_pkt,
  input  logic [LEN_W-1:0]  cfg_pkt_len,
  input  logic [LVL_W-1:0]  cfg_ae_thresh,
  input  logic              cfg_ae_ie,
  input  logic              cfg_uf_ie,
  input  logic              uf_clr,
  input  logic [WORD_W-1:0] fifo_rdata,
  input  logic              fifo_empty,
  input  logic [LVL_W-1:0]  fifo_level,
  output logic              fifo_pop,
  input  logic [LEN_W-1:0]  desc_len,
  input  logic              desc_empty,
  output logic              desc_pop,
  output logic              tx_line,
  output logic              st_clk_out,
  output logic              st_clk_oe,
  output logic              uf_sts,
  output logic              ae_sts,
  output logic              irq
);
  localparam int NBYTES = WORD_W / 8;
  localparam int BI_W   = $clog2(NBYTES);

  logic              launch;
  logic [WORD_W-1:0] word_q;
  logic [BI_W-1:0]   byte_q;
  logic [2:0]        nxt_bit;
  logic              lane_bit, lane_par;
  logic              uf_evt;

  tx_clk_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .half_ce    (half_ce),
    .ext_sclk   (ext_sclk),
    .cfg_clk_gen(cfg_clk_gen),
    .cfg_clk_inv(cfg_clk_inv),
    .launch     (launch),
    .st_clk_out (st_clk_out),
    .st_clk_oe  (st_clk_oe)
  );

  tx_lane_sel #(.WORD_W(WORD_W)) u_lane (
    .word    (word_q),
    .byte_idx(byte_q),
    .bit_idx (nxt_bit),
    .byte_rev(cfg_byte_rev),
    .bit_rev (cfg_bit_rev),
    .odd_par (cfg_odd_par),
    .dbit    (lane_bit),
    .par     (lane_par)
  );

  tx_frame_fsm #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch      (launch),
    .cfg_start_hi(cfg_start_hi),
    .cfg_reg_pkt (cfg_reg_pkt),
    .cfg_pkt_len (cfg_pkt_len),
    .fifo_rdata  (fifo_rdata),
    .fifo_empty  (fifo_empty),
    .desc_len    (desc_len),
    .desc_empty  (desc_empty),
    .lane_bit    (lane_bit),
    .lane_par    (lane_par),
    .word_q      (word_q),
    .byte_q      (byte_q),
    .nxt_bit     (nxt_bit),
    .fifo_pop    (fifo_pop),
    .desc_pop    (desc_pop),
    .uf_evt      (uf_evt),
    .tx_line     (tx_line)
  );

  tx_irq_ctl #(.LVL_W(LVL_W)) u_irq (
    .clk          (clk),
    .rst_n        (rst_n),
    .uf_evt       (uf_evt),
    .uf_clr       (uf_clr),
    .cfg_uf_ie    (cfg_uf_ie),
    .cfg_ae_ie    (cfg_ae_ie),
    .fifo_level   (fifo_level),
    .cfg_ae_thresh(cfg_ae_thresh),
    .uf_sts       (uf_sts),
    .ae_sts       (ae_sts),
    .irq          (irq)
  );
endmodule

// File: tb/serial_frame_tx_tb.sv
`timescale 1ns/1ps
module serial_frame_tx_tb;
  logic        clk, rst_n, half_ce, ext_sclk;
  logic        cfg_clk_gen, cfg_clk_inv, cfg_byte_rev, cfg_bit_rev;
  logic        cfg_odd_par, cfg_start_hi, cfg_reg_pkt;
  logic [7:0]  cfg_pkt_len;
  logic [5:0]  cfg_ae_thresh;
  logic        cfg_ae_ie, cfg_uf_ie, uf_clr;
  logic [31:0] fifo_rdata;
  logic        fifo_empty, fifo_pop;
  logic [5:0]  fifo_level;
  logic [7:0]  desc_len;
  logic        desc_empty, desc_pop;
  logic        tx_line, st_clk_out, st_clk_oe, uf_sts, ae_sts, irq;

  int nchk, nbad;

  // bench-side queues
  logic [31:0] fmem [64];
  logic [7:0]  dmem [16];
  int frd, fwr, drd, dwr;
  logic       lvl_force_en;
  logic [5:0] lvl_force;

  assign fifo_rdata = fmem[frd % 64];
  assign fifo_empty = (frd == fwr);
  assign fifo_level = lvl_force_en ? lvl_force : 6'(fwr - frd);
  assign desc_len   = dmem[drd % 16];
  assign desc_empty = (drd == dwr);

  always @(posedge clk) begin
    if (fifo_pop) frd <= frd + 1;
    if (desc_pop) drd <= drd + 1;
  end

  serial_frame_tx u_dut (
    .clk(clk), .rst_n(rst_n), .half_ce(half_ce), .ext_sclk(ext_sclk),
    .cfg_clk_gen(cfg_clk_gen), .cfg_clk_inv(cfg_clk_inv),
    .cfg_byte_rev(cfg_byte_rev), .cfg_bit_rev(cfg_bit_rev),
    .cfg_odd_par(cfg_odd_par), .cfg_start_hi(cfg_start_hi),
    .cfg_reg_pkt(cfg_reg_pkt), .cfg_pkt_len(cfg_pkt_len),
    .cfg_ae_thresh(cfg_ae_thresh), .cfg_ae_ie(cfg_ae_ie),
    .cfg_uf_ie(cfg_uf_ie), .uf_clr(uf_clr),
    .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty),
    .fifo_level(fifo_level), .fifo_pop(fifo_pop),
    .desc_len(desc_len), .desc_empty(desc_empty), .desc_pop(desc_pop),
    .tx_line(tx_line), .st_clk_out(st_clk_out), .st_clk_oe(st_clk_oe),
    .uf_sts(uf_sts), .ae_sts(ae_sts), .irq(irq)
  );

  // 50 MHz clock
  initial clk = 1'b0;
  always #10 clk = ~clk;

  // internal tick every 4 cycles; external clock toggles every 8 cycles
  int  hc_cnt;
  logic ext_run;
  initial begin hc_cnt = 0; half_ce = 1'b0; ext_sclk = 1'b0; end
  always @(posedge clk) begin
    hc_cnt  <= (hc_cnt + 1) % 4;
    half_ce <= (hc_cnt == 3);
  end
  always begin
    repeat (8) @(posedge clk);
    if (ext_run) ext_sclk <= ~ext_sclk;
  end

  // capture at the stable edge; count line changes in the wrong half
  logic cap [4096];
  int   ncap, viol;
  logic lvl_prev, tx_prev;
  initial begin ncap = 0; viol = 0; lvl_prev = 1'b0; tx_prev = 1'b1; end
  always @(negedge clk) begin
    logic lvl_now;
    lvl_now = cfg_clk_gen ? st_clk_out : ext_sclk;
    if (rst_n && tx_line != tx_prev && lvl_now != ~cfg_clk_inv) viol++;
    if (lvl_now != lvl_prev && lvl_now == cfg_clk_inv && ncap < 4096) begin
      cap[ncap] = tx_line;
      ncap++;
    end
    lvl_prev = lvl_now;
    tx_prev  = tx_line;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] frame_of(input logic [7:0] b);
    logic [10:0] f;
    f[10] = cfg_start_hi;
    for (int j = 0; j < 8; j++) f[9-j] = b[cfg_bit_rev ? 7 - j : j];
    f[1] = (^b) ^ cfg_odd_par;
    f[0] = ~cfg_start_hi;
    return f;
  endfunction

  function automatic logic [7:0] byte_of(input logic [31:0] w, input int k);
    int lane;
    lane = cfg_byte_rev ? 3 - k : k;
    return w[lane*8 +: 8];
  endfunction

  logic [7:0] exp_b [256];
  int nexp;

  // compare the captured stream against the expected byte list
  task automatic verify(input string req, input bit gaps_ok);
    int p;
    logic mk;
    p = 0;
    mk = ~cfg_start_hi;
    for (int k = 0; k < nexp; k++) begin
      int gap;
      logic [10:0] got;
      gap = 0;
      while (p < ncap && cap[p] == mk) begin p++; gap++; end
      got = '0;
      for (int i = 0; i < 11; i++) got[10-i] = (p + i < ncap) ? cap[p+i] : 1'bx;
      chk(got === frame_of(exp_b[k]), req, 32'(got), 32'(frame_of(exp_b[k])));
      if (!gaps_ok && k > 0)
        chk(gap == 0, "R2 back-to-back bytes", gap, 0);
      p += 11;
    end
    begin
      int nm;
      nm = 0;
      for (int i = p; i < ncap; i++) if (cap[i] != mk) nm++;
      chk(nm == 0, "R1 R8 marking after packet", nm, 0);
    end
  endtask

  task automatic bit_wait(input int n);
    repeat (n * (cfg_clk_gen ? 8 : 16)) @(posedge clk);
  endtask

  task automatic clear_queues();
    frd = 0; fwr = 0; drd = 0; dwr = 0;
  endtask

  task automatic run_case(input int c, input bit gen, input int nw);
    @(posedge clk);
    cfg_byte_rev = c[0]; cfg_bit_rev = c[1]; cfg_odd_par = c[2];
    cfg_start_hi = c[3]; cfg_clk_inv = c[4]; cfg_clk_gen = gen;
    cfg_reg_pkt = 1'b1; cfg_pkt_len = 8'(nw);
    bit_wait(4);
    ncap = 0; viol = 0;
    bit_wait(2);
    nexp = 0;
    for (int w = 0; w < nw; w++) begin
      logic [31:0] d;
      d = 32'hA5C3_0F81 ^ (32'(c * 7 + w) * 32'h1357_9BDF);
      fmem[w] = d;
      for (int k = 0; k < 4; k++) begin exp_b[nexp] = byte_of(d, k); nexp++; end
    end
    @(negedge clk);
    fwr = nw;
    bit_wait(nw * 44 + 12);
    verify("R2 R3 R4 R5 frame", 1'b0);
    chk(viol == 0, "R6 line changes after launch edge only", viol, 0);
    chk(frd == nw, "R8 one pop per longword", frd, nw);
    clear_queues();
  endtask

  initial begin
    nchk = 0; nbad = 0;
    rst_n = 1'b0; ext_run = 1'b0; uf_clr = 1'b0;
    cfg_clk_gen = 1'b1; cfg_clk_inv = 1'b0; cfg_byte_rev = 1'b0; cfg_bit_rev = 1'b0;
    cfg_odd_par = 1'b0; cfg_start_hi = 1'b0; cfg_reg_pkt = 1'b1; cfg_pkt_len = 8'd1;
    cfg_ae_thresh = 6'd0; cfg_ae_ie = 1'b0; cfg_uf_ie = 1'b0;
    lvl_force_en = 1'b0; lvl_force = '0;
    clear_queues();
    for (int i = 0; i < 64; i++) fmem[i] = '0;
    for (int i = 0; i < 16; i++) dmem[i] = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(tx_line == 1'b1, "R1 reset line marking", tx_line, 1);
    chk(fifo_pop == 1'b0 && desc_pop == 1'b0, "R8 no pop in reset", fifo_pop, 0);
    chk(uf_sts == 1'b0 && irq == 1'b0, "R10 reset status clear", uf_sts, 0);
    rst_n = 1'b1;

    // R7: generated clock toggles once per tick and is driven
    begin
      int tg;
      logic prv;
      tg = 0;
      @(negedge clk); prv = st_clk_out;
      repeat (40) begin @(negedge clk); if (st_clk_out != prv) tg++; prv = st_clk_out; end
      chk(tg == 10, "R7 generated clock toggles", tg, 10);
      chk(st_clk_oe == 1'b1, "R7 clock drive enabled", st_clk_oe, 1);
    end

    // sweep every order, parity, start sense and edge with the internal clock
    for (int c = 0; c < 32; c++) run_case(c, 1'b1, 2);

    // external clock, both edges
    ext_run = 1'b1;
    @(posedge clk);
    cfg_clk_gen = 1'b0;
    begin
      int tg;
      tg = 0;
      repeat (40) begin @(negedge clk); if (st_clk_out != 1'b0) tg++; end
      chk(tg == 0 && st_clk_oe == 1'b0, "R7 output clock idle when following", tg, 0);
    end
    run_case(5, 1'b0, 1);
    run_case(26, 1'b0, 1);
    ext_run = 1'b0;
    @(posedge clk);
    cfg_clk_gen = 1'b1; cfg_clk_inv = 1'b0; cfg_start_hi = 1'b0;
    cfg_byte_rev = 1'b0; cfg_bit_rev = 1'b0; cfg_odd_par = 1'b0;
    bit_wait(4);

    // R9: descriptor mode waits without a descriptor
    cfg_reg_pkt = 1'b0;
    for (int w = 0; w < 3; w++) fmem[w] = 32'h1000_0001 * (w + 3);
    ncap = 0;
    @(negedge clk);
    fwr = 3;
    bit_wait(20);
    begin
      int nm;
      nm = 0;
      for (int i = 0; i < ncap; i++) if (cap[i] != 1'b1) nm++;
      chk(nm == 0, "R9 line idle without descriptor", nm, 0);
      chk(frd == 0, "R9 no data pop without descriptor", frd, 0);
    end
    // descriptors 0, 2, 1
    dmem[0] = 8'd0; dmem[1] = 8'd2; dmem[2] = 8'd1;
    ncap = 0;
    nexp = 0;
    for (int w = 0; w < 3; w++)
      for (int k = 0; k < 4; k++) begin exp_b[nexp] = byte_of(fmem[w], k); nexp++; end
    @(negedge clk);
    dwr = 3;
    bit_wait(3 * 44 + 20);
    verify("R9 descriptor packets", 1'b1);
    chk(drd == 3, "R9 one descriptor per packet incl zero length", drd, 3);
    chk(frd == 3, "R9 data pops", frd, 3);
    clear_queues();

    // R10: underflow, packet of 3 with only 1 longword
    cfg_reg_pkt = 1'b1; cfg_pkt_len = 8'd3; cfg_uf_ie = 1'b1;
    bit_wait(4);
    fmem[0] = 32'hC0DE_5A17;
    nexp = 0;
    for (int k = 0; k < 4; k++) begin exp_b[nexp] = byte_of(fmem[0], k); nexp++; end
    ncap = 0;
    @(negedge clk);
    fwr = 1;
    bit_wait(44 + 20);
    verify("R10 frames before underflow", 1'b0);
    chk(uf_sts == 1'b1, "R10 underflow latched", uf_sts, 1);
    chk(irq == 1'b1, "R11 underflow interrupt enabled", irq, 1);
    @(negedge clk);
    cfg_uf_ie = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0, "R11 underflow interrupt masked", irq, 0);
    chk(uf_sts == 1'b1, "R10 status sticky", uf_sts, 1);
    uf_clr = 1'b1;
    @(negedge clk);
    uf_clr = 1'b0;
    chk(uf_sts == 1'b0, "R10 cleared by pulse", uf_sts, 0);
    clear_queues();

    // R12: almost-empty sweep
    lvl_force_en = 1'b1;
    cfg_ae_thresh = 6'd3;
    for (int ie = 0; ie < 2; ie++)
      for (int lv = 0; lv < 8; lv++) begin
        cfg_ae_ie = ie[0];
        lvl_force = 6'(lv);
        @(negedge clk);
        chk(ae_sts == (lv <= 3), "R12 almost-empty status", ae_sts, 32'(lv <= 3));
        chk(irq == (ie == 1 && lv <= 3), "R12 almost-empty interrupt", irq,
            32'(ie == 1 && lv <= 3));
      end

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule